// File: doc/BRIEF.md
# Byte-Serial ALU Blit Engine

This block is a bus master that moves a run of bytes through memory on an 8-bit data path. Software loads a source pointer, an optional second source pointer, a destination pointer, a length and an operation, then sets a start bit. The engine fetches one byte from the first source and, when dual-source mode is on, one byte from the second. It passes the bytes through an 8-bit ALU and writes the result to the destination. It then moves every pointer forward by one and repeats until the length runs out. No pointer has to be aligned, and a run may cross any number of 256-byte pages. At the end the engine raises an interrupt flag, which stays set until software clears it.

The ALU offers copy, bitwise logic, inversion, addition and subtraction. The carry (or borrow) flows from one byte to the next, so a long run can add two little-endian numbers. A lane field can clear the carry after every 2, 4 or 8 bytes. In that mode a single run adds whole arrays of 16-, 32- or 64-bit words, each word on its own, in place.

The memory port is a simple synchronous request/grant master. A request waits until the grant is seen. Read data comes back on the cycle after a granted read.

Top module: `blit_engine`

## Requirements
- R1: After reset, `busy`, `irq` and `mem_req` are all low.
- R2: The register map is: address 0 source A, 1 source B, 2 destination, 3 length, 4 control, 5 interrupt clear. Writing control with bit 15 set while idle starts a job that uses the values held at that moment.
- R3: Each byte reads source A at its current pointer, then, if dual mode is on, reads source B. It then writes the destination. Every pointer goes up by one per byte, from any start offset and across page boundaries.
- R4: A job writes exactly the programmed number of bytes (length 0 means 2^LEN_W bytes). It writes no address outside the destination range.
- R5: Accepted transfers follow the order read A, [read B], write, for every byte. No two writes are ever accepted back to back.
- R6: While `mem_req` is high and `mem_gnt` is low, the request, its direction, address and write data stay unchanged on the next cycle.
- R7: Control bits [2:0] select the result: 0 A, 1 A AND B, 2 A OR B, 3 A XOR B, 4 A+B+carry, 5 A−B−borrow, 6 NOT A, 7 B. Control bit 5 enables dual mode. With dual mode off, B is taken as 0.
- R8: The carry starts at 0 for every job. Only codes 4 and 5 produce a carry or borrow; other codes give 0. Control bits [4:3] select the lane size: 0 carries through the whole run, and 1, 2 and 3 clear the carry after byte indexes 1, 3 and 7 of every 2-, 4- and 8-byte group.
- R9: `irq` rises when the last write is accepted. It stays high until a write to address 5 clears it.
- R10: A control write that arrives while `busy` is high is dropped. The running job keeps its settings, and no second job follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | 16 | Register write data |
| busy | output | 1 | Job in progress |
| irq | output | 1 | Sticky completion flag |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | 8 | Write data |
| mem_gnt | input | 1 | Request accepted this cycle |
| mem_rdata | input | 8 | Read data, valid the cycle after a granted read |

## Verification
The bench aims at carry lanes. It fills the operands with 0xFF and 0x01, so a lane boundary cleared one byte early or late, or never cleared, changes visible result bytes. Grants are withheld at random, so an engine that drops a stalled request or samples read data on the wrong cycle shows up as corrupted bytes or a broken access order. A full-length job (length 0) and a run that crosses a page check the wrap of the length counter and the carry out of the pointers. A busy-time start that carries a different operation catches an engine that restarts or picks up new settings mid-run.

// File: rtl/blit_pkg.sv
package blit_pkg;

  typedef enum logic [2:0] {
    OP_COPY  = 3'd0,
    OP_AND   = 3'd1,
    OP_OR    = 3'd2,
    OP_XOR   = 3'd3,
    OP_ADD   = 3'd4,
    OP_SUB   = 3'd5,
    OP_NOTA  = 3'd6,
    OP_PASSB = 3'd7
  } blit_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RDA,
    ST_RDB,
    ST_CALC,
    ST_WR
  } blit_state_e;

  localparam logic [2:0] REG_SRCA = 3'd0;
  localparam logic [2:0] REG_SRCB = 3'd1;
  localparam logic [2:0] REG_DST  = 3'd2;
  localparam logic [2:0] REG_LEN  = 3'd3;
  localparam logic [2:0] REG_CTRL = 3'd4;
  localparam logic [2:0] REG_ICLR = 3'd5;

  localparam int CTRL_DUAL  = 5;
  localparam int CTRL_START = 15;

endpackage

// File: rtl/blit_alu.sv
module blit_alu
  import blit_pkg::*;
#(
  parameter int DW = 8
) (
  input  blit_op_e          op,
  input  logic [DW-1:0]     a,
  input  logic [DW-1:0]     b,
  input  logic              cin,
  output logic [DW-1:0]     res,
  output logic              cout
);

  logic [DW:0] sum;
  logic [DW:0] dif;

  always_comb begin
    sum  = {1'b0, a} + {1'b0, b} + {{DW{1'b0}}, cin};
    dif  = {1'b0, a} - {1'b0, b} - {{DW{1'b0}}, cin};
    cout = 1'b0;
    case (op)
      OP_COPY:  res = a;
      OP_AND:   res = a & b;
      OP_OR:    res = a | b;
      OP_XOR:   res = a ^ b;
      OP_ADD:   begin res = sum[DW-1:0]; cout = sum[DW]; end
      OP_SUB:   begin res = dif[DW-1:0]; cout = dif[DW]; end
      OP_NOTA:  res = ~a;
      default:  res = b;
    endcase
  end

endmodule

// File: rtl/blit_regs.sv
module blit_regs
  import blit_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_addr,
  input  logic [15:0]       cfg_wdata,
  input  logic              busy,
  input  logic              done,
  output logic [ADDR_W-1:0] src_a,
  output logic [ADDR_W-1:0] src_b,
  output logic [ADDR_W-1:0] dst,
  output logic [LEN_W-1:0]  len,
  output blit_op_e          op,
  output logic [1:0]        lane,
  output logic              dual,
  output logic              start,
  output logic              irq
);

  logic ctrl_wr;
  logic clr_wr;
  logic unused_bits;

  assign ctrl_wr     = cfg_we && (cfg_addr == REG_CTRL) && !busy;
  assign clr_wr      = cfg_we && (cfg_addr == REG_ICLR);
  assign unused_bits = ^cfg_wdata[14:6];

  always_ff @(posedge clk) begin
    if (rst) begin
      src_a <= '0;
      src_b <= '0;
      dst   <= '0;
      len   <= '0;
      op    <= OP_COPY;
      lane  <= 2'd0;
      dual  <= 1'b0;
      start <= 1'b0;
      irq   <= 1'b0;
    end else begin
      start <= ctrl_wr && cfg_wdata[CTRL_START];
      if (cfg_we && cfg_addr == REG_SRCA) src_a <= cfg_wdata[ADDR_W-1:0];
      if (cfg_we && cfg_addr == REG_SRCB) src_b <= cfg_wdata[ADDR_W-1:0];
      if (cfg_we && cfg_addr == REG_DST)  dst   <= cfg_wdata[ADDR_W-1:0];
      if (cfg_we && cfg_addr == REG_LEN)  len   <= cfg_wdata[LEN_W-1:0];
      if (ctrl_wr) begin
        op   <= blit_op_e'(cfg_wdata[2:0]);
        lane <= cfg_wdata[4:3];
        dual <= cfg_wdata[CTRL_DUAL];
      end
      if (done)        irq <= 1'b1;
      else if (clr_wr) irq <= 1'b0;
    end
  end

  // R9: the flag only drops on a clear write
  a_r9_irq_sticky: assert property (@(posedge clk) disable iff (rst)
    irq && !clr_wr |=> irq);

  // R9: the flag only rises at the end of a running job
  a_r9_irq_after_job: assert property (@(posedge clk) disable iff (rst)
    !irq && !done |=> !irq);

endmodule

// File: rtl/blit_seq.sv
module blit_seq
  import blit_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DW     = 8,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] src_a,
  input  logic [ADDR_W-1:0] src_b,
  input  logic [ADDR_W-1:0] dst,
  input  logic [LEN_W-1:0]  len,
  input  blit_op_e          op,
  input  logic [1:0]        lane,
  input  logic              dual,
  output logic              busy,
  output logic              done,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DW-1:0]     mem_wdata,
  input  logic              mem_gnt,
  input  logic [DW-1:0]     mem_rdata
);

  localparam int CNT_W = LEN_W + 1;
  localparam logic [CNT_W-1:0] FULL_RUN = {1'b1, {LEN_W{1'b0}}};

  blit_state_e       state;
  logic [ADDR_W-1:0] pa, pb, pd;
  logic [CNT_W-1:0]  remain;
  logic [2:0]        idx;
  logic [2:0]        lane_mask;
  logic              lane_end;
  logic              carry;
  logic              rd_vld;
  logic [DW-1:0]     a_hold;
  blit_op_e          op_q;
  logic [1:0]        lane_q;
  logic              dual_q;
  logic [DW-1:0]     alu_a, alu_b, alu_res;
  logic              alu_cout;

  assign busy      = (state != ST_IDLE);
  assign lane_mask = (3'b001 << lane_q) - 3'd1;
  assign lane_end  = (lane_q != 2'd0) && ((idx & lane_mask) == lane_mask);
  assign alu_a     = dual_q ? a_hold : mem_rdata;
  assign alu_b     = dual_q ? mem_rdata : '0;

  blit_alu #(.DW(DW)) i_alu (
    .op   (op_q),
    .a    (alu_a),
    .b    (alu_b),
    .cin  (carry),
    .res  (alu_res),
    .cout (alu_cout)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      pa        <= '0;
      pb        <= '0;
      pd        <= '0;
      remain    <= '0;
      idx       <= '0;
      carry     <= 1'b0;
      rd_vld    <= 1'b0;
      a_hold    <= '0;
      op_q      <= OP_COPY;
      lane_q    <= 2'd0;
      dual_q    <= 1'b0;
      done      <= 1'b0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      done   <= 1'b0;
      rd_vld <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          pa       <= src_a;
          pb       <= src_b;
          pd       <= dst;
          remain   <= (len == '0) ? FULL_RUN : {1'b0, len};
          idx      <= '0;
          carry    <= 1'b0;
          op_q     <= op;
          lane_q   <= lane;
          dual_q   <= dual;
          state    <= ST_RDA;
          mem_req  <= 1'b1;
          mem_we   <= 1'b0;
          mem_addr <= src_a;
        end
        ST_RDA: if (mem_gnt) begin
          pa     <= pa + 1'b1;
          rd_vld <= 1'b1;
          if (dual_q) begin
            state    <= ST_RDB;
            mem_addr <= pb;
          end else begin
            state   <= ST_CALC;
            mem_req <= 1'b0;
          end
        end
        ST_RDB: begin
          if (rd_vld) a_hold <= mem_rdata;
          if (mem_gnt) begin
            pb      <= pb + 1'b1;
            rd_vld  <= 1'b1;
            state   <= ST_CALC;
            mem_req <= 1'b0;
          end
        end
        ST_CALC: begin
          mem_wdata <= alu_res;
          carry     <= lane_end ? 1'b0 : alu_cout;
          idx       <= idx + 3'd1;
          state     <= ST_WR;
          mem_req   <= 1'b1;
          mem_we    <= 1'b1;
          mem_addr  <= pd;
        end
        ST_WR: if (mem_gnt) begin
          pd     <= pd + 1'b1;
          remain <= remain - 1'b1;
          mem_we <= 1'b0;
          if (remain == {{(CNT_W-1){1'b0}}, 1'b1}) begin
            state   <= ST_IDLE;
            mem_req <= 1'b0;
            done    <= 1'b1;
          end else begin
            state    <= ST_RDA;
            mem_addr <= pa;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R6: a stalled request is held unchanged
  a_r6_stall_hold: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_gnt |=> mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata));

  // R5: a granted write is followed by a read request or by idle
  a_r5_no_double_write: assert property (@(posedge clk) disable iff (rst)
    mem_req && mem_we && mem_gnt |=> !mem_we);

  // R10: job settings do not move while a job runs
  a_r10_settings_frozen: assert property (@(posedge clk) disable iff (rst)
    busy && $past(busy) |-> $stable(op_q) && $stable(dual_q) && $stable(lane_q));

  // R1: no request while idle
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_req);

endmodule

// File: rtl/blit_engine.sv
module blit_engine
  import blit_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DW     = 8,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_addr,
  input  logic [15:0]       cfg_wdata,
  output logic              busy,
  output logic              irq,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DW-1:0]     mem_wdata,
  input  logic              mem_gnt,
  input  logic [DW-1:0]     mem_rdata
);

  logic [ADDR_W-1:0] src_a, src_b, dst;
  logic [LEN_W-1:0]  len;
  blit_op_e          op;
  logic [1:0]        lane;
  logic              dual;
  logic              start;
  logic              done;

  blit_regs #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) i_regs (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .busy      (busy),
    .done      (done),
    .src_a     (src_a),
    .src_b     (src_b),
    .dst       (dst),
    .len       (len),
    .op        (op),
    .lane      (lane),
    .dual      (dual),
    .start     (start),
    .irq       (irq)
  );

  blit_seq #(.ADDR_W(ADDR_W), .DW(DW), .LEN_W(LEN_W)) i_seq (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .src_a     (src_a),
    .src_b     (src_b),
    .dst       (dst),
    .len       (len),
    .op        (op),
    .lane      (lane),
    .dual      (dual),
    .busy      (busy),
    .done      (done),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_gnt   (mem_gnt),
    .mem_rdata (mem_rdata)
  );

endmodule

// File: tb/test_blit_engine.sv
module test_blit_engine;

  localparam int CLK_PERIOD = 10;
  localparam int LEN_W      = 10;
  localparam int MEM_N      = 4096;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic        busy, irq, mem_req, mem_we;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic        mem_gnt = 1'b0;
  logic [7:0]  mem_rdata = '0;

  int tests = 0;
  int fails = 0;

  logic [7:0] mem  [MEM_N];
  logic [7:0] snap [MEM_N];
  logic [7:0] expm [MEM_N];

  int exp_reads = 1;
  int rd_run = 0;
  int ord_err = 0;
  int hold_err = 0;
  int wr_cnt = 0;
  logic        p_stall = 1'b0;
  logic        p_we = 1'b0;
  logic [15:0] p_addr = '0;
  logic [7:0]  p_wdata = '0;

  blit_engine #(.ADDR_W(16), .DW(8), .LEN_W(LEN_W)) i_blit_engine (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .busy(busy), .irq(irq), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) mem_gnt <= (($urandom % 10) < 6);

  always @(posedge clk) begin
    if (p_stall && !(mem_req && mem_we == p_we && mem_addr == p_addr && mem_wdata == p_wdata))
      hold_err <= hold_err + 1;
    p_stall <= mem_req && !mem_gnt;
    p_we    <= mem_we;
    p_addr  <= mem_addr;
    p_wdata <= mem_wdata;
    if (mem_req && mem_gnt) begin
      if (mem_we) begin
        mem[mem_addr[11:0]] <= mem_wdata;
        if (rd_run != exp_reads) ord_err <= ord_err + 1;
        rd_run <= 0;
        wr_cnt <= wr_cnt + 1;
      end else begin
        mem_rdata <= mem[mem_addr[11:0]];
        rd_run <= rd_run + 1;
      end
    end else begin
      mem_rdata <= 8'($urandom);
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic fill_rand(input int base, input int n);
    for (int i = 0; i < n; i++) mem[(base + i) % MEM_N] = 8'($urandom);
  endtask

  task automatic fill_const(input int base, input int n, input logic [7:0] v);
    for (int i = 0; i < n; i++) mem[(base + i) % MEM_N] = v;
  endtask

  function automatic logic [8:0] alu_ref(input int op, input logic [7:0] a, input logic [7:0] b, input logic c);
    logic [8:0] s;
    case (op)
      0: s = {1'b0, a};
      1: s = {1'b0, a & b};
      2: s = {1'b0, a | b};
      3: s = {1'b0, a ^ b};
      4: s = {1'b0, a} + {1'b0, b} + {8'd0, c};
      5: s = {1'b0, a} - {1'b0, b} - {8'd0, c};
      6: s = {1'b0, ~a};
      default: s = {1'b0, b};
    endcase
    return s;
  endfunction

  task automatic run_job(input int sa, input int sb, input int da, input int lenreg,
                         input int op, input int lane, input int dual, input bit poke,
                         input string req);
    int n;
    int mism;
    int waited;
    logic c;
    logic [8:0] r;
    logic [7:0] bv;
    n = (lenreg == 0) ? (1 << LEN_W) : lenreg;
    for (int i = 0; i < MEM_N; i++) snap[i] = mem[i];
    for (int i = 0; i < MEM_N; i++) expm[i] = mem[i];
    c = 1'b0;
    for (int i = 0; i < n; i++) begin
      bv = dual ? snap[(sb + i) % MEM_N] : 8'd0;
      r = alu_ref(op, snap[(sa + i) % MEM_N], bv, c);
      expm[(da + i) % MEM_N] = r[7:0];
      c = (op == 4 || op == 5) ? r[8] : 1'b0;
      if (lane != 0 && ((i & ((1 << lane) - 1)) == ((1 << lane) - 1))) c = 1'b0;
    end
    exp_reads = dual ? 2 : 1;
    ord_err = 0; hold_err = 0; wr_cnt = 0; rd_run = 0;
    reg_wr(3'd0, 16'(sa));
    reg_wr(3'd1, 16'(sb));
    reg_wr(3'd2, 16'(da));
    reg_wr(3'd3, 16'(lenreg));
    reg_wr(3'd4, 16'h8000 | 16'(dual << 5) | 16'(lane << 3) | 16'(op));
    if (poke) begin
      repeat (30) @(negedge clk);
      check("R10", "busy before poke", int'(busy), 1);
      reg_wr(3'd4, 16'h8000 | 16'h0020 | 16'd6);
    end
    waited = 0;
    while (!irq && waited < 60000) begin
      @(negedge clk);
      waited++;
    end
    check("R9", {req, " irq at end"}, int'(irq), 1);
    check(req, "busy at end", int'(busy), 0);
    mism = 0;
    for (int i = 0; i < MEM_N; i++) if (mem[i] !== expm[i]) mism++;
    check(req, "memory mismatches", mism, 0);
    check("R4", {req, " write count"}, wr_cnt, n);
    check("R5", {req, " access order errors"}, ord_err, 0);
    check("R6", {req, " stall hold errors"}, hold_err, 0);
    repeat (5) @(negedge clk);
    check("R9", {req, " irq sticky"}, int'(irq), 1);
    reg_wr(3'd5, 16'd0);
    check("R9", {req, " irq cleared"}, int'(irq), 0);
  endtask

  initial begin
    void'($urandom(32'd20240601));
    fill_rand(0, MEM_N);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1", "busy", int'(busy), 0);
    check("R1", "irq", int'(irq), 0);
    check("R1", "mem_req", int'(mem_req), 0);

    // R2 R3: odd offsets, run crosses pages
    run_job(32'h013, 0, 32'h5F7, 300, 0, 0, 0, 1'b0, "R3");
    // R7 each code
    run_job(32'h101, 32'h2C3, 32'h900, 37, 1, 0, 1, 1'b0, "R7");
    run_job(32'h101, 32'h2C3, 32'h900, 37, 2, 0, 1, 1'b0, "R7");
    run_job(32'h101, 32'h2C3, 32'h900, 37, 3, 0, 1, 1'b0, "R7");
    run_job(32'h0FE, 0,       32'hA05, 19, 6, 0, 0, 1'b0, "R7");
    run_job(32'h101, 32'h2C3, 32'h900, 21, 7, 0, 1, 1'b0, "R7");
    run_job(32'h101, 0,       32'h900, 21, 4, 0, 0, 1'b0, "R7");
    // R8 carry lanes with carries in every byte
    fill_const(32'h200, 32, 8'hFF);
    fill_const(32'h300, 32, 8'h01);
    for (int l = 0; l < 4; l++)
      run_job(32'h200, 32'h300, 32'hB00, 24, 4, l, 1, 1'b0, "R8");
    fill_const(32'h200, 32, 8'h00);
    run_job(32'h200, 32'h300, 32'hB00, 24, 5, 2, 1, 1'b0, "R8");
    run_job(32'h200, 32'h300, 32'hB00, 24, 5, 0, 1, 1'b0, "R8");
    // R4: length 0 means full run
    fill_rand(0, 1024);
    run_job(32'h000, 0, 32'h800, 0, 0, 0, 0, 1'b0, "R4");
    // R10: start while busy is dropped
    run_job(32'h040, 0, 32'hC40, 40, 0, 0, 0, 1'b1, "R10");
    repeat (40) @(negedge clk);
    check("R10", "no second job busy", int'(busy), 0);
    check("R10", "no second job irq", int'(irq), 0);
    // R2 randomized jobs
    for (int k = 0; k < 8; k++) begin
      fill_rand(0, MEM_N);
      run_job($urandom % 256, 32'h400 + ($urandom % 256), 32'h900 + ($urandom % 256),
              1 + ($urandom % 200), $urandom % 8, $urandom % 4, $urandom % 2, 1'b0, "R2");
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule